// File: doc/BRIEF.md
# ADC Channel Window Fault Monitor

This block sits behind one ADC channel and supervises two sample streams. The first stream carries raw converter samples. A fast window comparator checks it on every valid sample. The second stream carries the filtered or decimated samples. A slow window comparator checks each of these samples as the stage accepts it. Either comparator can raise the single channel fault output. Each comparator runs in one of two modes, and software can change the mode at run time:

- **Latching mode:** the fault is held until a clear pulse arrives.
- **Hysteresis mode:** the fault sets outside an outer window and releases inside a narrower inner window.

The filtered stream also passes through a calibration adder on its way out. The adder adds a signed offset that cancels analog offsets. The sum saturates at the signed range instead of wrapping. The result leaves through a registered valid/ready output.

All thresholds, modes and the offset arrive on plain configuration ports. A register front end outside this block drives them.

Top module: `adc_fault_monitor`

## Requirements
- R1: While `rst_ni` is low, and on the first falling edge after it is released, `fault_o` and `out_valid_o` are 0.
- R2: When `raw_valid_i` is 1 at a rising edge, the fast comparator checks `raw_data_i` as a signed two's-complement value. A value below `fast_lo_i` or above `fast_hi_i` sets the fast fault state at that edge. A value exactly equal to either limit counts as inside.
- R3: A filtered sample is accepted at a rising edge where `filt_valid_i` and `filt_ready_o` are both 1. The slow comparator checks each accepted sample against `slow_lo_i` and `slow_hi_i` by the same signed, limit-inclusive rule.
- R4: With the mode input at 0 (latching), a fault state stays set after samples return inside the window. It clears at the edge where the clear pulse `fault_clr_i` is 1. If a violating sample arrives at that same edge, the state stays set.
- R5: With the mode input at 1 (hysteresis), a violating sample sets the state. The state clears only when a sample lies inside the inner window (inner low to inner high, limits inclusive). Samples between the inner and outer windows leave the state unchanged.
- R6: In hysteresis mode, `fault_clr_i` has no effect on that comparator's fault state.
- R7: `fault_o` is a register holding the OR of the fast and slow fault states. It shows the effect of a sample at the same rising edge where the sample is taken.
- R8: An accepted filtered sample appears on `out_data_o` as sample plus `cal_offset_i` (signed). `out_valid_o` is 1 from the rising edge that accepts the sample.
- R9: The calibrated sum saturates to the range from -2^(W-1) to 2^(W-1)-1; it never wraps.
- R10: `filt_ready_o` equals NOT `out_valid_o` OR `out_ready_i`. While `out_valid_o` is 1 and `out_ready_i` is 0, `out_data_o` and `out_valid_o` hold. `out_valid_o` falls after a transfer when no new sample is accepted.
- R11: A raw sample with `raw_valid_i` at 0, or a filtered sample that is not accepted, has no effect on any fault state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_valid_i | input | 1 | Raw sample strobe |
| raw_data_i | input | W | Raw sample, signed |
| filt_valid_i | input | 1 | Filtered sample valid |
| filt_ready_o | output | 1 | Filtered sample ready |
| filt_data_i | input | W | Filtered sample, signed |
| out_valid_o | output | 1 | Calibrated sample valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | W | Calibrated, saturated sample |
| fast_lo_i | input | W | Fast window low limit |
| fast_hi_i | input | W | Fast window high limit |
| fast_in_lo_i | input | W | Fast inner low limit (hysteresis release) |
| fast_in_hi_i | input | W | Fast inner high limit (hysteresis release) |
| fast_mode_i | input | 1 | Fast mode: 0 latching, 1 hysteresis |
| slow_lo_i | input | W | Slow window low limit |
| slow_hi_i | input | W | Slow window high limit |
| slow_in_lo_i | input | W | Slow inner low limit |
| slow_in_hi_i | input | W | Slow inner high limit |
| slow_mode_i | input | 1 | Slow mode: 0 latching, 1 hysteresis |
| fault_clr_i | input | 1 | Clear pulse for latched faults |
| cal_offset_i | input | W | Signed calibration offset |
| fault_o | output | 1 | Registered channel fault |

## Verification
Three results have fixed timing:

- **Fault output:** the effect of a sample on `fault_o` is due exactly one rising edge after the sample is presented.
- **Calibrated output:** the calibrated value and `out_valid_o` are also due one edge after acceptance.
- **Ready:** `filt_ready_o` is combinational, so it is correct in the same cycle.

The bench drives all inputs on the falling edge and predicts the next register state with its own model. It checks `filt_ready_o` shortly after driving. It compares `fault_o`, `out_valid_o` and `out_data_o` on the following falling edge, one rising edge later. No result is therefore read in the cycle where it changes.

// File: rtl/adcfm_pkg.sv
package adcfm_pkg;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_HYST  = 1'b1
  } fault_mode_e;

endpackage

// File: rtl/adcfm_window_cmp.sv
module adcfm_window_cmp
  import adcfm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_vld_i,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] in_lo_i,
  input  logic [W-1:0] in_hi_i,
  input  logic         mode_i,
  input  logic         clr_i,
  output logic         flag_nxt_o,
  output logic         flag_o
);

  fault_mode_e mode;
  logic        outer_viol;
  logic        inner_ok;
  logic        flag_q;
  logic        flag_d;
  logic        flag_en;

  assign mode = fault_mode_e'(mode_i);

  always_comb begin
    outer_viol = ($signed(smp_i) < $signed(lo_i)) || ($signed(smp_i) > $signed(hi_i));
    inner_ok   = ($signed(smp_i) >= $signed(in_lo_i)) && ($signed(smp_i) <= $signed(in_hi_i));
  end

  always_comb begin
    flag_d = flag_q;
    if (mode == MODE_HYST) begin
      if (smp_vld_i && outer_viol)    flag_d = 1'b1;
      else if (smp_vld_i && inner_ok) flag_d = 1'b0;
    end else begin
      if (clr_i)                      flag_d = 1'b0;
      if (smp_vld_i && outer_viol)    flag_d = 1'b1;
    end
  end

  assign flag_en = smp_vld_i | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_nxt_o = flag_d;
  assign flag_o     = flag_q;

  AST_OUTSIDE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && (($signed(smp_i) < $signed(lo_i)) || ($signed(smp_i) > $signed(hi_i))))
    |=> flag_q) else $error("window violation did not set fault"); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !mode_i && !clr_i) |=> flag_q)
    else $error("latched fault dropped without clear"); // R4

  AST_HYST_CLR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && mode_i && !smp_vld_i) |=> flag_q)
    else $error("hysteresis fault dropped without sample"); // R6

  AST_NO_SAMPLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !smp_vld_i) |=> !flag_q)
    else $error("fault set without a sample"); // R11

endmodule

// File: rtl/adcfm_cal_stage.sv
module adcfm_cal_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_vld_i,
  output logic         in_rdy_o,
  input  logic [W-1:0] in_data_i,
  input  logic [W-1:0] offset_i,
  output logic         out_vld_o,
  input  logic         out_rdy_i,
  output logic [W-1:0] out_data_o
);

  localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

  logic         accept;
  logic [W:0]   sum_ext;
  logic [W-1:0] sum_sat;
  logic         vld_q, vld_d;
  logic [W-1:0] data_q;

  assign in_rdy_o = !vld_q || out_rdy_i;
  assign accept   = in_vld_i && in_rdy_o;

  always_comb begin
    sum_ext = {in_data_i[W-1], in_data_i} + {offset_i[W-1], offset_i};
    if (sum_ext[W] != sum_ext[W-1]) sum_sat = sum_ext[W] ? SAT_MIN : SAT_MAX;
    else                            sum_sat = sum_ext[W-1:0];
  end

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (out_rdy_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (accept) data_q <= sum_sat;
  end

  assign out_vld_o  = vld_q;
  assign out_data_o = data_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !out_rdy_i) |=> (vld_q && $stable(data_q)))
    else $error("output changed while stalled"); // R10

  AST_SAT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_data_i[W-1] && !offset_i[W-1]) |=> !data_q[W-1])
    else $error("positive sum wrapped negative"); // R9

  AST_SAT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_data_i[W-1] && offset_i[W-1]) |=> data_q[W-1])
    else $error("negative sum wrapped positive"); // R9

endmodule

// File: rtl/adc_fault_monitor.sv
module adc_fault_monitor
  import adcfm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         raw_valid_i,
  input  logic [W-1:0] raw_data_i,
  input  logic         filt_valid_i,
  output logic         filt_ready_o,
  input  logic [W-1:0] filt_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o,
  input  logic [W-1:0] fast_lo_i,
  input  logic [W-1:0] fast_hi_i,
  input  logic [W-1:0] fast_in_lo_i,
  input  logic [W-1:0] fast_in_hi_i,
  input  logic         fast_mode_i,
  input  logic [W-1:0] slow_lo_i,
  input  logic [W-1:0] slow_hi_i,
  input  logic [W-1:0] slow_in_lo_i,
  input  logic [W-1:0] slow_in_hi_i,
  input  logic         slow_mode_i,
  input  logic         fault_clr_i,
  input  logic [W-1:0] cal_offset_i,
  output logic         fault_o
);

  localparam int NCMP = 2;

  logic            filt_accept;
  logic            filt_rdy;
  logic [NCMP-1:0] flag_nxt;
  logic [NCMP-1:0] flag_cur;
  logic            fault_q;
  logic            fault_d;

  assign filt_accept = filt_valid_i && filt_rdy;
  assign filt_ready_o = filt_rdy;

  adcfm_window_cmp #(.W(W)) u_fast_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (raw_valid_i),
    .smp_i     (raw_data_i),
    .lo_i      (fast_lo_i),
    .hi_i      (fast_hi_i),
    .in_lo_i   (fast_in_lo_i),
    .in_hi_i   (fast_in_hi_i),
    .mode_i    (fast_mode_i),
    .clr_i     (fault_clr_i),
    .flag_nxt_o(flag_nxt[0]),
    .flag_o    (flag_cur[0])
  );

  adcfm_window_cmp #(.W(W)) u_slow_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (filt_accept),
    .smp_i     (filt_data_i),
    .lo_i      (slow_lo_i),
    .hi_i      (slow_hi_i),
    .in_lo_i   (slow_in_lo_i),
    .in_hi_i   (slow_in_hi_i),
    .mode_i    (slow_mode_i),
    .clr_i     (fault_clr_i),
    .flag_nxt_o(flag_nxt[1]),
    .flag_o    (flag_cur[1])
  );

  adcfm_cal_stage #(.W(W)) u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (filt_valid_i),
    .in_rdy_o  (filt_rdy),
    .in_data_i (filt_data_i),
    .offset_i  (cal_offset_i),
    .out_vld_o (out_valid_o),
    .out_rdy_i (out_ready_i),
    .out_data_o(out_data_o)
  );

  always_comb fault_d = |flag_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign fault_o = fault_q;

  AST_FAULT_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (|flag_cur)) else $error("fault output differs from comparator states"); // R7

  AST_READY_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o) |-> filt_ready_o) else $error("ready low with empty output"); // R10

endmodule

// File: tb/adc_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module adc_fault_monitor_tb_top;
  localparam int W = 16;
  localparam int SMAX = 32767;
  localparam int SMIN = -32768;

  logic clk = 1'b0;
  logic rst_ni;
  logic raw_valid, filt_valid, out_ready, fast_mode, slow_mode, fault_clr;
  logic [W-1:0] raw_data, filt_data, cal_offset;
  logic [W-1:0] fast_lo, fast_hi, fast_in_lo, fast_in_hi;
  logic [W-1:0] slow_lo, slow_hi, slow_in_lo, slow_in_hi;
  logic filt_ready, out_valid, fault;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  logic m_fast, m_slow, m_fault, m_ov;
  int m_od;

  always #2 clk = ~clk;

  adc_fault_monitor #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .raw_valid_i(raw_valid), .raw_data_i(raw_data),
    .filt_valid_i(filt_valid), .filt_ready_o(filt_ready), .filt_data_i(filt_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .fast_lo_i(fast_lo), .fast_hi_i(fast_hi), .fast_in_lo_i(fast_in_lo),
    .fast_in_hi_i(fast_in_hi), .fast_mode_i(fast_mode),
    .slow_lo_i(slow_lo), .slow_hi_i(slow_hi), .slow_in_lo_i(slow_in_lo),
    .slow_in_hi_i(slow_in_hi), .slow_mode_i(slow_mode),
    .fault_clr_i(fault_clr), .cal_offset_i(cal_offset), .fault_o(fault)
  );

  function automatic logic cmp_next(logic f, logic v, int s, int lo, int hi,
                                    int ilo, int ihi, logic hy, logic c);
    logic r;
    r = f;
    if (hy) begin
      if (v && (s < lo || s > hi)) r = 1'b1;
      else if (v && s >= ilo && s <= ihi) r = 1'b0;
    end else begin
      if (c) r = 1'b0;
      if (v && (s < lo || s > hi)) r = 1'b1;
    end
    return r;
  endfunction

  function automatic int sat_add(int a, int b);
    int s;
    s = a + b;
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    return s;
  endfunction

  function automatic int sv(logic [W-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic tick(string tag);
    logic pr, acc, fn, sn;
    #1;
    pr = !m_ov || out_ready;
    check({tag, " ready R10"}, int'(filt_ready), int'(pr));
    acc = filt_valid && pr;
    fn = cmp_next(m_fast, raw_valid, sv(raw_data), sv(fast_lo), sv(fast_hi),
                  sv(fast_in_lo), sv(fast_in_hi), fast_mode, fault_clr);
    sn = cmp_next(m_slow, acc, sv(filt_data), sv(slow_lo), sv(slow_hi),
                  sv(slow_in_lo), sv(slow_in_hi), slow_mode, fault_clr);
    @(posedge clk);
    m_fast = fn;
    m_slow = sn;
    m_fault = fn | sn;
    if (acc) begin
      m_od = sat_add(sv(filt_data), sv(cal_offset));
      m_ov = 1'b1;
    end else if (out_ready) begin
      m_ov = 1'b0;
    end
    @(negedge clk);
    check({tag, " fault R7"}, int'(fault), int'(m_fault));
    check({tag, " valid R8"}, int'(out_valid), int'(m_ov));
    if (m_ov) check({tag, " data R8"}, sv(out_data), m_od);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    raw_valid = 0; filt_valid = 0; out_ready = 1; fault_clr = 0;
    fast_mode = 0; slow_mode = 0;
    raw_data = '0; filt_data = '0; cal_offset = '0;
    fast_lo = -16'sd1000; fast_hi = 16'sd1000; fast_in_lo = -16'sd500; fast_in_hi = 16'sd500;
    slow_lo = -16'sd2000; slow_hi = 16'sd2000; slow_in_lo = -16'sd1500; slow_in_hi = 16'sd1500;
    m_fast = 0; m_slow = 0; m_fault = 0; m_ov = 0; m_od = 0;
    repeat (3) @(negedge clk);
    check("R1 fault in reset", int'(fault), 0);
    check("R1 valid in reset", int'(out_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 fault after release", int'(fault), 0);
    check("R1 valid after release", int'(out_valid), 0);

    // Fast comparator, latching
    raw_valid = 1; raw_data = 16'sd1000;   tick("R2 equal high limit inside");
    raw_data = -16'sd1000;                 tick("R2 equal low limit inside");
    raw_data = 16'sd1001;                  tick("R2 above high sets");
    raw_data = 16'sd0;                     tick("R4 latched after return");
    fault_clr = 1; raw_data = -16'sd1001;  tick("R4 violation beats clear");
    raw_valid = 0;                         tick("R4 clear releases");
    fault_clr = 0;
    raw_data = 16'sd30000;                 tick("R11 invalid raw ignored");

    // Fast comparator, hysteresis
    fast_mode = 1; raw_valid = 1;
    raw_data = 16'sd1500;                  tick("R5 outer violation sets");
    raw_data = 16'sd700;                   tick("R5 between windows holds");
    raw_valid = 0; fault_clr = 1;          tick("R6 clear ignored in hysteresis");
    fault_clr = 0; raw_valid = 1;
    raw_data = 16'sd500;                   tick("R5 inner limit releases");
    raw_valid = 0; fast_mode = 0;

    // Slow comparator and output path
    filt_valid = 1; filt_data = -16'sd2001; tick("R3 below slow low sets");
    filt_valid = 0; fault_clr = 1;          tick("R4 slow clear");
    fault_clr = 0;
    filt_valid = 1; filt_data = 16'sd2000;  tick("R3 equal slow limit inside");
    cal_offset = 16'sd100; filt_data = 16'sd32700;  tick("R9 positive saturation");
    cal_offset = -16'sd100; filt_data = -16'sd32700; tick("R9 negative saturation");
    cal_offset = 16'sd7; filt_data = -16'sd12;       tick("R8 plain offset");
    fault_clr = 1; filt_valid = 0;          tick("R4 clear slow");
    fault_clr = 0;

    // Stall
    out_ready = 0; filt_valid = 1; filt_data = 16'sd3;
    tick("R10 stall accept");
    filt_data = 16'sd4000; tick("R10 stalled hold");
    tick("R11 stalled sample not taken");
    out_ready = 1; tick("R10 drain");
    filt_valid = 0; tick("R10 valid falls");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        int a, b;
        a = $urandom_range(1, 2000); b = $urandom_range(1, 2000);
        fast_lo = W'(-a); fast_hi = W'(b); fast_in_lo = W'(-(a/2)); fast_in_hi = W'(b/2);
        a = $urandom_range(1, 2000); b = $urandom_range(1, 2000);
        slow_lo = W'(-a); slow_hi = W'(b); slow_in_lo = W'(-(a/2)); slow_in_hi = W'(b/2);
        fast_mode = $urandom_range(0, 1); slow_mode = $urandom_range(0, 1);
        cal_offset = W'($urandom_range(0, 1) ? $urandom_range(0, 4000) - 2000
                                             : $urandom_range(0, 65535));
      end
      raw_valid  = $urandom_range(0, 1);
      filt_valid = $urandom_range(0, 1);
      out_ready  = ($urandom_range(0, 3) != 0);
      fault_clr  = ($urandom_range(0, 15) == 0);
      raw_data   = ($urandom_range(0, 15) == 0) ? W'($urandom_range(0, 65535))
                                                : W'(int'($urandom_range(0, 5000)) - 2500);
      filt_data  = ($urandom_range(0, 15) == 0) ? W'($urandom_range(0, 65535))
                                                : W'(int'($urandom_range(0, 5000)) - 2500);
      tick("R7 random");
    end
    summary();
  end
endmodule